// File: doc/BRIEF.md
# PLL Lock Clock-Switch Indicator

This block sits beside a receiver's PLL and its output clock multiplexer. It samples a raw lock-detect level from the PLL and produces three things. The first is a qualified receive-error flag. The second is the select line for the output master-clock multiplexer, which chooses the crystal clock while unlocked and the PLL clock once locked. The third is an active-low transition marker that is low exactly while that clock hand-over is in progress. Downstream logic watches the marker's edges to learn when the output clock may be irregular and when the lock state has changed.

All decisions are timed against a word-clock strobe that an internal divider makes from the crystal clock. The lock-in qualification length, the unlock hold length and the divider ratio are parameters. Lock-in and unlock follow different edge rules. On lock-in the marker falls on a word strobe and rises together with the error flag's release. On unlock the marker falls together with the error flag and rises a fixed number of word strobes later. In both cases the clock select moves at the middle of the low marker.

Top module: `pll_switch_indicator`

## Requirements
- R1: While reset is asserted and right after it, errFlag is 1, switchN is 1 and clkSelPll is 0 (crystal clock selected).
- R2: wordStrobe is high for one crystal clock cycle out of every WORD_DIV cycles.
- R3: lockRaw passes through a two-stage synchroniser. On lock-in, switchN falls only on the clock edge that directly follows a cycle with wordStrobe high, and errFlag stays 1 at that edge.
- R4: On lock-in, clkSelPll rises once switchN has been low for exactly QUAL_WORDS word strobes.
- R5: On lock-in, switchN rises on the same edge that errFlag falls, after QUAL_WORDS+1 word strobes of low time. errFlag never falls at any other moment.
- R6: On unlock, switchN falls on the same edge that errFlag rises.
- R7: On unlock, clkSelPll falls at the first word strobe of the low marker, and switchN rises after exactly HOLD_WORDS word strobes.
- R8: If the synchronised lock level drops during lock-in qualification, the sequence is abandoned. switchN returns to 1, errFlag stays 1 and clkSelPll stays 0.
- R9: If the lock level returns while an unlock hold is running, it has no effect until the hold has completed. Lock-in then starts from the unlocked state.
- R10: clkSelPll changes only while switchN is 0, both before and after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lockRaw | input | 1 | Raw PLL lock-detect level, asynchronous |
| wordStrobe | output | 1 | One-cycle word-clock strobe from the crystal divider |
| errFlag | output | 1 | Qualified receive-error flag, 1 while not locked |
| switchN | output | 1 | Active-low clock-transition marker |
| clkSelPll | output | 1 | Output clock select: 1 = PLL clock, 0 = crystal clock |

## Verification
The lock input is driven with a table of high and low periods. Long high periods complete a lock-in, and short high periods are cut off inside qualification, which separates a full hand-over from an abandoned one. Long low periods let the unlock hold finish. A very short low period brings lock back while the hold is still running, which shows whether the hold ignores the lock level. A port-level monitor counts word strobes while the marker is low and checks the strobe count at the select change and at the marker's rising edge, for each kind of transition. A final directed test asserts reset while the block is locked.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

  typedef enum logic [2:0] {
    ST_UNLOCKED = 3'd0,
    ST_QUAL     = 3'd1,
    ST_LOCK_SW  = 3'd2,
    ST_LOCKED   = 3'd3,
    ST_UNL_FALL = 3'd4,
    ST_UNL_HOLD = 3'd5
  } cswState_t;

  // control -> datapath
  typedef struct packed {
    logic loadQual;
    logic loadHold;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic wordTick;
    logic lockSync;
    logic cntLast;
  } dpStatus_t;

endpackage

// File: rtl/cksw_datapath.sv
module cksw_datapath
  import cksw_pkg::*;
#(
  parameter int WORD_DIV    = 4,
  parameter int QUAL_WORDS  = 5,
  parameter int HOLD_WORDS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockRaw,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int DW      = (WORD_DIV > 1) ? $clog2(WORD_DIV) : 1;
  localparam int CNT_MAX = (QUAL_WORDS > HOLD_WORDS) ? QUAL_WORDS : HOLD_WORDS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  // lock-detect synchroniser
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= lockRaw;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  // word-clock divider
  logic [DW-1:0] divCnt;
  logic          wordTick;

  assign wordTick = (divCnt == DW'(WORD_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (wordTick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  // word counter shared by qualification and unlock hold
  logic [CW-1:0] wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wordCnt <= '0;
    else if (strobe.loadQual)             wordCnt <= CW'(QUAL_WORDS);
    else if (strobe.loadHold)             wordCnt <= CW'(HOLD_WORDS - 1);
    else if (wordTick && wordCnt != '0)   wordCnt <= wordCnt - 1'b1;
  end

  assign status.wordTick = wordTick;
  assign status.lockSync = syncQ[SYNC_STAGES-1];
  assign status.cntLast  = (wordCnt == CW'(1));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |=> !wordTick);

  p_load_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadQual && strobe.loadHold));

endmodule

// File: rtl/cksw_ctrl.sv
module cksw_ctrl
  import cksw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        errFlag,
  output logic        switchN,
  output logic        clkSelPll
);

  cswState_t stateQ, stateD;

  always_comb begin
    stateD          = stateQ;
    strobe.loadQual = 1'b0;
    strobe.loadHold = 1'b0;
    unique case (stateQ)
      ST_UNLOCKED: if (status.lockSync && status.wordTick) begin
        stateD          = ST_QUAL;
        strobe.loadQual = 1'b1;
      end
      ST_QUAL: begin
        if (!status.lockSync)                          stateD = ST_UNLOCKED;
        else if (status.wordTick && status.cntLast)    stateD = ST_LOCK_SW;
      end
      ST_LOCK_SW: begin
        if (!status.lockSync)      stateD = ST_UNL_FALL;
        else if (status.wordTick)  stateD = ST_LOCKED;
      end
      ST_LOCKED: if (!status.lockSync) stateD = ST_UNL_FALL;
      ST_UNL_FALL: if (status.wordTick) begin
        stateD          = ST_UNL_HOLD;
        strobe.loadHold = 1'b1;
      end
      ST_UNL_HOLD: if (status.wordTick && status.cntLast) stateD = ST_UNLOCKED;
      default: stateD = ST_UNLOCKED;
    endcase
  end

  // registered outputs decoded from the next state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_UNLOCKED;
      errFlag   <= 1'b1;
      switchN   <= 1'b1;
      clkSelPll <= 1'b0;
    end else begin
      stateQ    <= stateD;
      errFlag   <= (stateD != ST_LOCKED);
      switchN   <= (stateD == ST_UNLOCKED) || (stateD == ST_LOCKED);
      clkSelPll <= (stateD == ST_LOCK_SW) || (stateD == ST_LOCKED) ||
                   (stateD == ST_UNL_FALL);
    end
  end

  p_lockin_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(switchN) && $past(errFlag)) |-> ($past(status.wordTick) && errFlag));

  p_err_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> $rose(switchN));

  p_unlock_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(switchN) && !$past(errFlag)) |-> errFlag);

  p_sel_midpulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkSelPll) |-> (!switchN && !$past(switchN)));

  p_abandon_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(switchN) && errFlag) |-> !clkSelPll);

endmodule

// File: rtl/pll_switch_indicator.sv
module pll_switch_indicator
  import cksw_pkg::*;
#(
  parameter int WORD_DIV    = 4,
  parameter int QUAL_WORDS  = 5,
  parameter int HOLD_WORDS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lockRaw,
  output logic wordStrobe,
  output logic errFlag,
  output logic switchN,
  output logic clkSelPll
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cksw_datapath #(
    .WORD_DIV   (WORD_DIV),
    .QUAL_WORDS (QUAL_WORDS),
    .HOLD_WORDS (HOLD_WORDS),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk    (clk),
    .rstN   (rstN),
    .lockRaw(lockRaw),
    .strobe (strobe),
    .status (status)
  );

  cksw_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .strobe   (strobe),
    .errFlag  (errFlag),
    .switchN  (switchN),
    .clkSelPll(clkSelPll)
  );

  assign wordStrobe = status.wordTick;

endmodule

// File: tb/pll_switch_indicator_tb_top.sv
module pll_switch_indicator_tb_top;

  localparam int WORD_DIV   = 4;
  localparam int QUAL_WORDS = 5;
  localparam int HOLD_WORDS = 3;
  localparam int NVEC       = 6;

  // stimulus table: lock high cycles, lock low cycles, expect locked, expect idle after low
  localparam int    VEC_ON   [NVEC] = '{50, 12, 60, 60, 35, 20};
  localparam int    VEC_OFF  [NVEC] = '{30, 30,  5, 30, 30, 30};
  localparam bit    VEC_LOCK [NVEC] = '{1,  0,  1,  1,  1,  0};
  localparam bit    VEC_IDLE [NVEC] = '{1,  1,  0,  1,  1,  1};
  localparam string VEC_TAG  [NVEC] = '{"R5", "R8", "R5", "R9", "R5", "R8"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockRaw = 1'b0;
  logic wordStrobe, errFlag, switchN, clkSelPll;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  pll_switch_indicator #(
    .WORD_DIV  (WORD_DIV),
    .QUAL_WORDS(QUAL_WORDS),
    .HOLD_WORDS(HOLD_WORDS)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .lockRaw   (lockRaw),
    .wordStrobe(wordStrobe),
    .errFlag   (errFlag),
    .switchN   (switchN),
    .clkSelPll (clkSelPll)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  // port-level monitor
  bit prevSw = 1, prevErr = 1, prevSel = 0, prevTick = 0, seenTick = 0;
  int kind = 0;  // 0 none, 1 lock-in, 2 unlock
  int pulseTicks = 0;
  int gap = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevSw = 1; prevErr = 1; prevSel = 0; prevTick = 0; seenTick = 0;
      kind = 0; pulseTicks = 0; gap = 0;
    end else begin
      // R2: strobe spacing
      if (wordStrobe) begin
        if (seenTick) check(gap + 1 == WORD_DIV, "R2 strobe period", gap + 1, WORD_DIV);
        gap = 0;
        seenTick = 1;
      end else begin
        gap++;
      end
      // falling marker
      if (prevSw && !switchN) begin
        pulseTicks = 0;
        if (!prevErr) begin
          kind = 2;
          check(errFlag == 1'b1, "R6 err rises with marker fall", errFlag, 1);
        end else begin
          kind = 1;
          check(prevTick == 1'b1, "R3 lock-in fall after strobe", prevTick, 1);
        end
      end
      // select change
      if (clkSelPll != prevSel) begin
        check(!switchN && !prevSw, "R10 select moves inside pulse", switchN, 0);
        if (kind == 1 && clkSelPll)
          check(pulseTicks == QUAL_WORDS, "R4 select rise strobes", pulseTicks, QUAL_WORDS);
        if (kind == 2 && !clkSelPll)
          check(pulseTicks == 1, "R7 select fall strobes", pulseTicks, 1);
      end
      // rising marker
      if (!prevSw && switchN) begin
        if (kind == 1 && !errFlag) begin
          check(pulseTicks == QUAL_WORDS + 1, "R5 lock-in pulse strobes",
                pulseTicks, QUAL_WORDS + 1);
          check(prevErr == 1'b1, "R5 err falls with marker rise", prevErr, 1);
        end else if (kind == 1) begin
          check(clkSelPll == 1'b0, "R8 abandon keeps crystal", clkSelPll, 0);
        end else if (kind == 2) begin
          // R9: hold length is unaffected by lock returning early
          check(pulseTicks == HOLD_WORDS, "R7 unlock hold strobes", pulseTicks, HOLD_WORDS);
          check(errFlag == 1'b1 && clkSelPll == 1'b0, "R7 unlocked after hold",
                {errFlag, clkSelPll}, 2);
        end
        kind = 0;
      end
      if (prevErr && !errFlag)
        check(!prevSw && switchN, "R5 err release only with marker rise", switchN, 1);
      if (!switchN && wordStrobe) pulseTicks++;
      prevSw = switchN; prevErr = errFlag; prevSel = clkSelPll; prevTick = wordStrobe;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    waitCycles(3);
    check(errFlag == 1 && switchN == 1 && clkSelPll == 0, "R1 in reset",
          {errFlag, switchN, clkSelPll}, 3'b110);
    rstN = 1'b1;
    waitCycles(20);
    check(errFlag == 1 && switchN == 1 && clkSelPll == 0, "R1 after reset",
          {errFlag, switchN, clkSelPll}, 3'b110);

    for (int v = 0; v < NVEC; v++) begin
      lockRaw = 1'b1;
      waitCycles(VEC_ON[v]);
      if (VEC_LOCK[v])
        check(errFlag == 0 && clkSelPll == 1 && switchN == 1,
              {VEC_TAG[v], " locked at end of high"}, {errFlag, switchN, clkSelPll}, 3'b011);
      else
        check(errFlag == 1 && clkSelPll == 0, {VEC_TAG[v], " not locked at end of high"},
              {errFlag, clkSelPll}, 2'b10);
      lockRaw = 1'b0;
      waitCycles(VEC_OFF[v]);
      if (VEC_IDLE[v])
        check(errFlag == 1 && switchN == 1 && clkSelPll == 0,
              {VEC_TAG[v], " idle after low"}, {errFlag, switchN, clkSelPll}, 3'b110);
    end

    // R8: lock drops during qualification, checked while still low
    lockRaw = 1'b1;
    waitCycles(14);
    check(switchN == 0 && errFlag == 1, "R8 inside qualification", {switchN, errFlag}, 2'b01);
    lockRaw = 1'b0;
    waitCycles(6);
    check(switchN == 1 && errFlag == 1 && clkSelPll == 0, "R8 abandoned",
          {errFlag, switchN, clkSelPll}, 3'b110);

    // R1: reset while locked
    lockRaw = 1'b1;
    waitCycles(50);
    check(errFlag == 0 && clkSelPll == 1, "R1 locked before reset", {errFlag, clkSelPll}, 2'b01);
    rstN = 1'b0;
    waitCycles(2);
    check(errFlag == 1 && switchN == 1 && clkSelPll == 0, "R1 reset while locked",
          {errFlag, switchN, clkSelPll}, 3'b110);
    lockRaw = 1'b0;
    rstN = 1'b1;
    waitCycles(10);
    check(errFlag == 1 && switchN == 1 && clkSelPll == 0, "R1 idle after reset release",
          {errFlag, switchN, clkSelPll}, 3'b110);

    finishRun();
  end

endmodule